// File: doc/BRIEF.md
# Frame Data Scrambler / Descrambler

This block whitens the payload words of a serial-link frame so that long runs of identical data do not concentrate emitted energy at a few frequencies. A 16-bit linear feedback shift register produces a pseudorandom 32-bit mask for each payload word, and the mask is XORed onto that word. Control words (primitives) are never masked and never move the generator, so the mask sequence depends only on how many payload words have passed since the last start-of-frame marker.

The generator reloads a fixed all-ones seed whenever a start-of-frame beat is seen. XOR is its own inverse, so one instance serves both directions. On transmit it sits after the checksum stage and before the line encoder. On receive it sits after the line decoder and before the checksum check. Scrambled words fed through a second pass come back as the original words. The stream carries a valid bit, a 32-bit word, a primitive flag and a start-of-frame flag. All four leave the block together, after a parameterised latency of zero or one clock.

Top module: `frame_scrambler`

## Requirements
- R1: The mask sequence is the bit stream a[k] with a[0..15] = 1 and a[k+16] = a[k] ^ a[k+1] ^ a[k+3] ^ a[k+12] (the x^16+x^15+x^13+x^4+1 register). Payload word n after a reseed (valid=1, prim=0, sof=0) leaves as its input XOR mask n, where mask bit i equals a[32n+i].
- R2: A beat with valid=1 and sof=1 reloads the seed 0xFFFF, so the next payload word uses mask 0.
- R3: Reset loads the seed. The first payload word after reset, with no start-of-frame beat before it, uses mask 0. This also holds when reset interrupts a frame.
- R4: A beat with valid=1 and prim=1 leaves with its word, its prim flag and its sof flag unchanged.
- R5: Idle cycles (valid=0) and primitive beats do not advance the generator, so the payload word after them uses the next unused mask.
- R6: A start-of-frame beat leaves unmasked even when prim=0. When reseed and advance compete in that cycle, the reseed wins.
- R7: With OUT_REG=1, out_valid, out_data, out_prim and out_sof follow the input beat by exactly one clock. out_valid is 0 during and straight after reset.
- R8: A frame already scrambled, passed again after a start-of-frame beat, comes out as the original words.
- R9: A primitive beat without sof, such as an end-of-frame word, does not reseed. A payload word after it continues the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_data | input | DW | Input word |
| in_prim | input | 1 | Input word is a primitive |
| in_sof | input | 1 | Input word is a start-of-frame marker |
| out_valid | output | 1 | Output beat present |
| out_data | output | DW | Masked or passed-through word |
| out_prim | output | 1 | Primitive flag, delayed |
| out_sof | output | 1 | Start-of-frame flag, delayed |

## Verification
Reseeding and advancing the generator can both be requested in one cycle. This happens when a start-of-frame beat arrives with its primitive flag low. The bench sends such a beat in the middle of a frame whose generator has already advanced. It then checks two things: the beat itself leaves unmasked, and the next payload word carries mask 0 rather than the next mask in the old sequence. A second case sends a start-of-frame beat directly after a payload word. There the register is written by an advance and then by a reseed on consecutive edges, and the following word must again use mask 0.

// File: rtl/frame_scrambler_pkg.sv
package frame_scrambler_pkg;
   localparam int unsigned WORD_W      = 32;
   localparam int unsigned GEN_W       = 16;
   localparam logic [15:0] GEN_SEED    = 16'hFFFF;
   // feedback from state bits 15, 14, 12 and 3
   localparam logic [15:0] GEN_TAPS    = 16'hD008;

   typedef struct packed {
      logic valid;
      logic prim;
      logic sof;
   } beat_ctl_t;
endpackage

// File: rtl/fsx_lfsr.sv
module fsx_lfsr #(
   parameter int unsigned W         = 16,
   parameter int unsigned STEP_BITS = 32,
   parameter logic [W-1:0] SEED     = '1,
   parameter logic [W-1:0] TAPS     = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reseed,
   input  logic                 advance,
   output logic [STEP_BITS-1:0] mask,
   output logic [W-1:0]         state_q
);
   generate
      if (W < 2) begin : g_bad_w
         $error("fsx_lfsr: W must be at least 2");
      end
      if (STEP_BITS < 1) begin : g_bad_step
         $error("fsx_lfsr: STEP_BITS must be positive");
      end
   endgenerate

   logic [W-1:0] state_adv;

   always_comb begin
      logic [W-1:0] st;
      st = state_q;
      for (int i = 0; i < STEP_BITS; i++) begin
         mask[i] = st[W-1];
         st      = {st[W-2:0], ^(st & TAPS)};
      end
      state_adv = st;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       state_q <= SEED;
      else if (reseed)  state_q <= SEED;
      else if (advance) state_q <= state_adv;
   end
endmodule

// File: rtl/fsx_out_stage.sv
module fsx_out_stage #(
   parameter int unsigned DW  = 32,
   parameter int unsigned LAT = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          v_in,
   input  logic          p_in,
   input  logic          s_in,
   input  logic [DW-1:0] d_in,
   output logic          v_out,
   output logic          p_out,
   output logic          s_out,
   output logic [DW-1:0] d_out
);
   generate
      if (LAT > 1) begin : g_bad_lat
         $error("fsx_out_stage: LAT must be 0 or 1");
      end
      if (LAT == 1) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_out <= 1'b0;
               p_out <= 1'b0;
               s_out <= 1'b0;
               d_out <= '0;
            end else begin
               v_out <= v_in;
               p_out <= p_in;
               s_out <= s_in;
               d_out <= d_in;
            end
         end
      end else begin : g_comb
         assign v_out = v_in;
         assign p_out = p_in;
         assign s_out = s_in;
         assign d_out = d_in;
      end
   endgenerate
endmodule

// File: rtl/frame_scrambler.sv
module frame_scrambler
   import frame_scrambler_pkg::*;
#(
   parameter int unsigned DW      = WORD_W,
   parameter int unsigned OUT_REG = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [DW-1:0] in_data,
   input  logic          in_prim,
   input  logic          in_sof,
   output logic          out_valid,
   output logic [DW-1:0] out_data,
   output logic          out_prim,
   output logic          out_sof
);
   generate
      if (DW == 0) begin : g_bad_dw
         $error("frame_scrambler: DW must be positive");
      end
   endgenerate

   beat_ctl_t        ctl;
   logic             do_reseed;
   logic             do_mask;
   logic [DW-1:0]    mask;
   logic [GEN_W-1:0] lfsr_q;
   logic [DW-1:0]    data_mod;

   assign ctl       = '{valid: in_valid, prim: in_prim, sof: in_sof};
   assign do_reseed = ctl.valid & ctl.sof;
   assign do_mask   = ctl.valid & ~ctl.prim & ~ctl.sof;

   fsx_lfsr #(
      .W        (GEN_W),
      .STEP_BITS(DW),
      .SEED     (GEN_SEED),
      .TAPS     (GEN_TAPS)
   ) gen_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .reseed (do_reseed),
      .advance(do_mask),
      .mask   (mask),
      .state_q(lfsr_q)
   );

   assign data_mod = do_mask ? (in_data ^ mask) : in_data;

   fsx_out_stage #(
      .DW (DW),
      .LAT(OUT_REG)
   ) out_i (
      .clk  (clk),
      .rst_n(rst_n),
      .v_in (ctl.valid),
      .p_in (ctl.prim),
      .s_in (ctl.sof),
      .d_in (data_mod),
      .v_out(out_valid),
      .p_out(out_prim),
      .s_out(out_sof),
      .d_out(out_data)
   );
endmodule

// File: rtl/frame_scrambler_chk.sv
module frame_scrambler_chk #(
   parameter int unsigned DW   = 32,
   parameter int unsigned LAT  = 1,
   parameter int unsigned GW   = 16,
   parameter logic [GW-1:0] SEED = '1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic [DW-1:0] in_data,
   input logic          in_prim,
   input logic          in_sof,
   input logic          out_valid,
   input logic [DW-1:0] out_data,
   input logic          out_prim,
   input logic          out_sof,
   input logic [GW-1:0] lfsr_q
);
   // R2
   reseed_loads_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> (lfsr_q == SEED));

   // R5
   idle_holds_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid || (in_prim && !in_sof)) |=> $stable(lfsr_q));

   generate
      if (LAT == 1) begin : g_lat1
         // R4
         prim_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_prim) |=> (out_prim && out_data == $past(in_data)));
         // R6
         sof_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_sof) |=> (out_sof && out_data == $past(in_data)));
         // R7
         valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
         // R7
         idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
      end else begin : g_lat0
         // R4
         prim_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_prim) |-> (out_prim && out_data == in_data));
         // R6
         sof_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && in_sof) |-> (out_sof && out_data == in_data));
         // R7
         valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);
      end
   endgenerate
endmodule

bind frame_scrambler frame_scrambler_chk #(
   .DW  (DW),
   .LAT (OUT_REG),
   .GW  (frame_scrambler_pkg::GEN_W),
   .SEED(frame_scrambler_pkg::GEN_SEED)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .in_data  (in_data),
   .in_prim  (in_prim),
   .in_sof   (in_sof),
   .out_valid(out_valid),
   .out_data (out_data),
   .out_prim (out_prim),
   .out_sof  (out_sof),
   .lfsr_q   (lfsr_q)
);

// File: tb/frame_scrambler_tb_top.sv
module frame_scrambler_tb_top;
   localparam int DW = 32;
   localparam int NV = 16;
   localparam int SEQ_BITS = 4096;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic          in_prim = 1'b0;
   logic          in_sof = 1'b0;
   logic          out_valid;
   logic [DW-1:0] out_data;
   logic          out_prim;
   logic          out_sof;

   int errors = 0;
   int checks = 0;
   int widx = 0;
   bit done = 0;
   logic seq [SEQ_BITS];
   logic [DW-1:0] last_out;

   always #5 clk = ~clk;

   frame_scrambler #(.DW(DW), .OUT_REG(1)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_data(in_data), .in_prim(in_prim), .in_sof(in_sof),
      .out_valid(out_valid), .out_data(out_data), .out_prim(out_prim), .out_sof(out_sof)
   );

   // {valid, prim, sof, data}
   localparam logic [34:0] VEC [NV] = '{
      {3'b111, 32'hBC00_0001},   // SOF primitive
      {3'b100, 32'h0000_0000},   // payload
      {3'b100, 32'hFFFF_FFFF},
      {3'b000, 32'h1234_5678},   // idle
      {3'b100, 32'hA5A5_5A5A},
      {3'b110, 32'h7C00_0002},   // hold-type primitive
      {3'b100, 32'h0F0F_0F0F},
      {3'b110, 32'h7C00_0003},   // end-of-frame primitive
      {3'b100, 32'hDEAD_BEEF},   // continues, no reseed
      {3'b100, 32'h0000_0001},
      {3'b101, 32'h1111_2222},   // SOF with prim low, mid-frame
      {3'b100, 32'h8000_0000},
      {3'b100, 32'h0000_0000},
      {3'b111, 32'hBC00_0001},   // SOF right after payload
      {3'b100, 32'hCAFE_F00D},
      {3'b100, 32'h0000_0000}
   };

   function automatic logic [DW-1:0] mword(input int w);
      logic [DW-1:0] m;
      for (int i = 0; i < DW; i++) m[i] = seq[(w * DW + i) % SEQ_BITS];
      return m;
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic beat(input logic v, input logic p, input logic s, input logic [DW-1:0] d);
      logic [DW-1:0] exp_d;
      string tag;
      exp_d = d;
      if (v && s) begin
         tag = p ? "R2" : "R6";
         widx = 0;
      end else if (v && p) begin
         tag = "R4";
      end else if (v) begin
         tag = (widx == 0) ? "R1" : "R5";
         exp_d = d ^ mword(widx);
         widx++;
      end else begin
         tag = "R5";
      end
      in_valid = v; in_prim = p; in_sof = s; in_data = d;
      @(posedge clk);
      @(negedge clk);
      chk({tag, " R7 valid"}, {31'b0, out_valid}, {31'b0, v});
      if (v) begin
         chk({tag, " data"}, out_data, exp_d);
         chk({tag, " flags"}, {30'b0, out_prim, out_sof}, {30'b0, p, s});
         last_out = out_data;
      end
   endtask

   initial begin
      for (int k = 0; k < 16; k++) seq[k] = 1'b1;
      for (int k = 16; k < SEQ_BITS; k++)
         seq[k] = seq[k-16] ^ seq[k-15] ^ seq[k-13] ^ seq[k-4];

      // reset state (R7)
      repeat (3) @(negedge clk);
      chk("R7 reset valid", {31'b0, out_valid}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7 post-reset valid", {31'b0, out_valid}, 32'd0);

      // R3: first payload after reset uses mask 0
      widx = 0;
      beat(1'b1, 1'b0, 1'b0, 32'h0000_0000);
      chk("R3 mask0 after reset", last_out, mword(0));
      beat(1'b1, 1'b0, 1'b0, 32'h0000_0000);

      // table walk (R1 R2 R4 R5 R6 R9)
      for (int i = 0; i < NV; i++)
         beat(VEC[i][34], VEC[i][33], VEC[i][32], VEC[i][31:0]);

      // R3: reset in the middle of a frame
      beat(1'b0, 1'b0, 1'b0, '0);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      widx = 0;
      beat(1'b1, 1'b0, 1'b0, 32'h5555_AAAA);
      chk("R3 mid-frame reset mask0", last_out, 32'h5555_AAAA ^ mword(0));

      // R8: scramble then descramble
      begin
         logic [DW-1:0] orig [4];
         logic [DW-1:0] scr [4];
         orig[0] = 32'h0123_4567; orig[1] = 32'h89AB_CDEF;
         orig[2] = 32'h0000_0000; orig[3] = 32'hFFFF_0000;
         beat(1'b1, 1'b1, 1'b1, 32'hBC00_0001);
         for (int j = 0; j < 4; j++) begin
            beat(1'b1, 1'b0, 1'b0, orig[j]);
            scr[j] = last_out;
         end
         beat(1'b1, 1'b1, 1'b1, 32'hBC00_0001);
         for (int j = 0; j < 4; j++) begin
            in_valid = 1'b1; in_prim = 1'b0; in_sof = 1'b0; in_data = scr[j];
            @(posedge clk);
            @(negedge clk);
            chk("R8 round trip", out_data, orig[j]);
         end
         widx = 4;
      end
      beat(1'b0, 1'b0, 1'b0, '0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule